// File: doc/BRIEF.md
# Instruction Prefetch Queue

This block keeps a small byte queue of code ahead of an execution unit. It owns the only memory port. While the memory port has nothing else to do, it reads code bytes at its own prefetch pointer and appends them at the queue tail. In the same cycles the execution side takes bytes from the head through a valid/request pair. Data reads and writes from the execution side share the same memory port and win over prefetching. A taken control transfer empties the queue and moves the prefetch pointer to the new target.

The memory port width is a parameter. With a 16-bit port the queue holds 6 bytes and each fetch brings a whole aligned word. With an 8-bit port the queue holds 4 bytes and each fetch brings a single byte. Every bus cycle keeps the request raised for a fixed number of clocks (4 by default) and ends on the first acknowledge at or after that count. One idle clock follows each bus cycle.

Top module: `instr_prefetch_queue`

## Requirements
- R1: While reset is held and after it is released, the queue is empty, `pop_valid` is low and `mem_req` is low. The first bus cycle after reset is a read at address `RESET_PTR`.
- R2: Each bus cycle holds `mem_req` for exactly `BUS_CLKS` clocks when `mem_ack` stays high. `mem_addr`, `mem_we` and `mem_wdata` are stable for the whole cycle.
- R3: Popped bytes come out in ascending address order starting at the prefetch pointer. The pointer advances by one for each byte placed in the queue.
- R4: A pop and an append can happen in the same clock, and neither waits for the other.
- R5: A data request seen while the port is idle starts a bus cycle at the next clock edge, using `data_addr` and `data_we`. When a fetch is in flight, a data request waits only for that fetch to end and is served before any further fetch. `data_done` is high during the final clock of the data cycle, and `data_rdata` then carries `mem_rdata`. A write drives `data_wdata` onto `mem_wdata`.
- R6: A `flush` empties the queue, so `pop_valid` is low in the next cycle. The next fetch reads at `flush_addr`. `pop_valid` stays low until the first target byte arrives.
- R7: A fetch that is in flight when `flush` arrives completes on the bus, with `mem_req` still high in the next cycle. Its returned bytes are discarded.
- R8: A fetch starts only when the free space is at least the port width in bytes: 2 on a 16-bit port, 1 on an 8-bit port. With less free space, `mem_req` stays low.
- R9: On a 16-bit port, `mem_rdata[7:0]` holds the byte at the even address of the word and `mem_rdata[15:8]` holds the byte at the odd address. A fetch at an odd pointer takes one byte from `mem_rdata[15:8]`, and all later fetches are aligned two-byte fetches.
- R10: The queue holds at most 6 bytes on a 16-bit port and at most 4 bytes on an 8-bit port. From empty, with nothing popped, it fills in 3 fetches or 4 fetches respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pop_req | input | 1 | Execution side takes the head byte |
| pop_valid | output | 1 | Head byte is available |
| pop_data | output | 8 | Head byte |
| flush | input | 1 | Taken control transfer: empty the queue |
| flush_addr | input | AW | New prefetch address |
| data_req | input | 1 | Execution side data access request, held until done |
| data_addr | input | AW | Data access address |
| data_we | input | 1 | Data access is a write |
| data_wdata | input | BUS_W | Data to write |
| data_rdata | output | BUS_W | Read data, valid with data_done |
| data_done | output | 1 | Final clock of the data bus cycle |
| mem_req | output | 1 | Bus cycle active |
| mem_addr | output | AW | Bus byte address |
| mem_we | output | 1 | Bus cycle is a write |
| mem_wdata | output | BUS_W | Bus write data |
| mem_rdata | input | BUS_W | Bus read data |
| mem_ack | input | 1 | Memory ready; ends the cycle once the minimum length is reached |

## Verification
The assertions check on every clock that bus cycles hold their address and control stable and have the fixed length. They also check that an idle port with a data request starts that request next, that a flush leaves the head invalid and does not cut short a fetch in flight, that a fetch begins only with enough free space, and that the queue never exceeds its depth. Only the bench scenarios can show the actual byte contents. These cover the ordering across odd and even targets and the single-byte first fetch, that a dropped fetch never leaks into the queue, the fill counts of both port widths, the refetch after a single pop, and the read data and written values of data accesses.

// File: rtl/ipq_pkg.sv
package ipq_pkg;

    typedef enum logic [1:0] {
        BUS_IDLE  = 2'd0,
        BUS_FETCH = 2'd1,
        BUS_DATA  = 2'd2
    } bus_kind_e;

    function automatic int qdepth_for(input int bus_w);
        return (bus_w == 16) ? 6 : 4;
    endfunction

endpackage

// File: rtl/ipq_byte_store.sv
module ipq_byte_store #(
    parameter int DEPTH = 6,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic [1:0]    push_n,
    input  logic [15:0]   push_bytes,
    input  logic          pop,
    output logic [7:0]    head_byte,
    output logic [CW-1:0] count,
    output logic [CW-1:0] free
);

    typedef struct packed {
        logic [PW-1:0] head;
        logic [CW-1:0] count;
    } ctl_t;

    ctl_t       ctl_q, ctl_d;
    logic [7:0] mem_q [DEPTH];
    logic [7:0] mem_d [DEPTH];
    logic [PW-1:0] wr0, wr1;

    function automatic logic [PW-1:0] wrap(input int x);
        if (x >= DEPTH) return PW'(x - DEPTH);
        return PW'(x);
    endfunction

    always_comb begin
        ctl_d = ctl_q;
        mem_d = mem_q;
        wr0 = wrap(int'(ctl_q.head) + int'(ctl_q.count));
        wr1 = wrap(int'(wr0) + 1);
        if (push_n != 2'd0) mem_d[wr0] = push_bytes[7:0];
        if (push_n == 2'd2) mem_d[wr1] = push_bytes[15:8];
        if (pop) ctl_d.head = wrap(int'(ctl_q.head) + 1);
        if (flush) begin
            ctl_d.head  = '0;
            ctl_d.count = '0;
        end else begin
            ctl_d.count = ctl_q.count + CW'(push_n) - CW'(pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'h00;
        end else begin
            ctl_q <= ctl_d;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign head_byte = mem_q[ctl_q.head];
    assign count     = ctl_q.count;
    assign free      = CW'(DEPTH) - ctl_q.count;

    a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.count <= CW'(DEPTH));

    a_r3_pop_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> ctl_q.count != '0);

endmodule

// File: rtl/ipq_bus_ctl.sv
module ipq_bus_ctl import ipq_pkg::*; #(
    parameter int BUS_W = 16,
    parameter int AW = 20,
    parameter int BUS_CLKS = 4,
    parameter int FB = 2,
    parameter int CW = 3,
    parameter logic [AW-1:0] RESET_PTR = '0,
    localparam int CYW = (BUS_CLKS > 1) ? $clog2(BUS_CLKS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CW-1:0]    free,
    input  logic             flush,
    input  logic [AW-1:0]    flush_addr,
    input  logic             data_req,
    input  logic [AW-1:0]    data_addr,
    input  logic             data_we,
    input  logic [BUS_W-1:0] data_wdata,
    output logic [BUS_W-1:0] data_rdata,
    output logic             data_done,
    output logic             mem_req,
    output logic [AW-1:0]    mem_addr,
    output logic             mem_we,
    output logic [BUS_W-1:0] mem_wdata,
    input  logic [BUS_W-1:0] mem_rdata,
    input  logic             mem_ack,
    output logic [1:0]       push_n,
    output logic [15:0]      push_bytes,
    output logic             fetch_busy
);

    localparam logic [CYW-1:0] LAST = CYW'(BUS_CLKS - 1);

    typedef struct packed {
        bus_kind_e        kind;
        logic [CYW-1:0]   cyc;
        logic [AW-1:0]    addr;
        logic             we;
        logic [BUS_W-1:0] wdata;
        logic             drop;
        logic [AW-1:0]    ptr;
    } bus_t;

    bus_t        bus_q, bus_d;
    logic        bus_end;
    logic [1:0]  lane_n;
    logic [15:0] lane_bytes;

    if (BUS_W == 16) begin : g_wide
        assign lane_n     = bus_q.addr[0] ? 2'd1 : 2'd2;
        assign lane_bytes = bus_q.addr[0] ? {8'h00, mem_rdata[15:8]} : mem_rdata[15:0];
    end else begin : g_narrow
        assign lane_n     = 2'd1;
        assign lane_bytes = {8'h00, mem_rdata[7:0]};
    end

    assign bus_end = (bus_q.kind != BUS_IDLE) && (bus_q.cyc == LAST) && mem_ack;

    always_comb begin
        bus_d      = bus_q;
        push_n     = 2'd0;
        push_bytes = lane_bytes;
        if (bus_q.kind != BUS_IDLE && bus_q.cyc != LAST) bus_d.cyc = bus_q.cyc + 1'b1;
        if (bus_end) begin
            bus_d.kind = BUS_IDLE;
            bus_d.cyc  = '0;
            bus_d.drop = 1'b0;
            if (bus_q.kind == BUS_FETCH && !bus_q.drop && !flush) begin
                push_n    = lane_n;
                bus_d.ptr = bus_q.ptr + AW'(lane_n);
            end
        end else if (bus_q.kind == BUS_IDLE) begin
            if (data_req) begin
                bus_d.kind  = BUS_DATA;
                bus_d.addr  = data_addr;
                bus_d.we    = data_we;
                bus_d.wdata = data_wdata;
            end else if (!flush && free >= CW'(FB)) begin
                bus_d.kind = BUS_FETCH;
                bus_d.addr = bus_q.ptr;
                bus_d.we   = 1'b0;
            end
        end
        if (flush) begin
            bus_d.ptr = flush_addr;
            if (bus_q.kind == BUS_FETCH && !bus_end) bus_d.drop = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_q      <= '0;
            bus_q.kind <= BUS_IDLE;
            bus_q.ptr  <= RESET_PTR;
        end else begin
            bus_q <= bus_d;
        end
    end

    assign mem_req    = bus_q.kind != BUS_IDLE;
    assign mem_addr   = bus_q.addr;
    assign mem_we     = bus_q.we;
    assign mem_wdata  = bus_q.wdata;
    assign data_done  = bus_end && bus_q.kind == BUS_DATA;
    assign data_rdata = mem_rdata;
    assign fetch_busy = bus_q.kind == BUS_FETCH;

    a_r2_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !(bus_q.cyc == LAST && mem_ack)) |=>
        (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    a_r2_cycle_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_req) |-> $past(bus_q.cyc) == LAST);

    a_r5_data_first: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_req && data_req) |=>
        (mem_req && mem_addr == $past(data_addr) && mem_we == $past(data_we)));

    a_r7_inflight_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && mem_req && !(bus_q.cyc == LAST && mem_ack)) |=> mem_req);

endmodule

// File: rtl/instr_prefetch_queue.sv
module instr_prefetch_queue import ipq_pkg::*; #(
    parameter int BUS_W = 16,
    parameter int AW = 20,
    parameter int BUS_CLKS = 4,
    parameter logic [AW-1:0] RESET_PTR = AW'('h00010)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pop_req,
    output logic             pop_valid,
    output logic [7:0]       pop_data,
    input  logic             flush,
    input  logic [AW-1:0]    flush_addr,
    input  logic             data_req,
    input  logic [AW-1:0]    data_addr,
    input  logic             data_we,
    input  logic [BUS_W-1:0] data_wdata,
    output logic [BUS_W-1:0] data_rdata,
    output logic             data_done,
    output logic             mem_req,
    output logic [AW-1:0]    mem_addr,
    output logic             mem_we,
    output logic [BUS_W-1:0] mem_wdata,
    input  logic [BUS_W-1:0] mem_rdata,
    input  logic             mem_ack
);

    localparam int QDEPTH = qdepth_for(BUS_W);
    localparam int FB     = BUS_W / 8;
    localparam int CW     = $clog2(QDEPTH + 1);

    logic [CW-1:0] q_count, q_free;
    logic [1:0]    push_n;
    logic [15:0]   push_bytes;
    logic          pop_fire, fetch_busy;

    assign pop_valid = (q_count != '0) && !flush;
    assign pop_fire  = pop_req && pop_valid;

    ipq_byte_store #(.DEPTH(QDEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push_n(push_n), .push_bytes(push_bytes), .pop(pop_fire),
        .head_byte(pop_data), .count(q_count), .free(q_free)
    );

    ipq_bus_ctl #(
        .BUS_W(BUS_W), .AW(AW), .BUS_CLKS(BUS_CLKS),
        .FB(FB), .CW(CW), .RESET_PTR(RESET_PTR)
    ) u_bus (
        .clk(clk), .rst_n(rst_n), .free(q_free),
        .flush(flush), .flush_addr(flush_addr),
        .data_req(data_req), .data_addr(data_addr), .data_we(data_we),
        .data_wdata(data_wdata), .data_rdata(data_rdata), .data_done(data_done),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .push_n(push_n), .push_bytes(push_bytes), .fetch_busy(fetch_busy)
    );

    a_r6_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !pop_valid);

    a_r8_fetch_threshold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fetch_busy) |-> q_free >= CW'(FB));

endmodule

// File: tb/instr_prefetch_queue_bench.sv
module instr_prefetch_queue_bench;

    localparam int CLK_PERIOD = 10;
    localparam logic [19:0] RST_PTR = 20'h00010;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    function automatic logic [7:0] mb(input logic [19:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // wide (16-bit) instance
    logic        pop_req = 0, pop_valid, flush = 0, data_req = 0, data_we = 0, data_done;
    logic [7:0]  pop_data;
    logic [19:0] flush_addr = '0, data_addr = '0, mem_addr;
    logic [15:0] data_wdata = '0, data_rdata, mem_wdata, mem_rdata;
    logic        mem_req, mem_we, mem_ack;

    assign mem_rdata = {mb(mem_addr | 20'h1), mb(mem_addr & ~20'h1)};
    assign mem_ack   = mem_req;

    instr_prefetch_queue #(.BUS_W(16), .RESET_PTR(RST_PTR)) u_instr_prefetch_queue (
        .clk(clk), .rst_n(rst_n), .pop_req(pop_req), .pop_valid(pop_valid), .pop_data(pop_data),
        .flush(flush), .flush_addr(flush_addr), .data_req(data_req), .data_addr(data_addr),
        .data_we(data_we), .data_wdata(data_wdata), .data_rdata(data_rdata), .data_done(data_done),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    // narrow (8-bit) instance
    logic        n_pop_req = 0, n_pop_valid, n_data_done, n_mem_req, n_mem_we;
    logic [7:0]  n_pop_data, n_data_rdata, n_mem_wdata, n_mem_rdata;
    logic [19:0] n_mem_addr;

    assign n_mem_rdata = mb(n_mem_addr);

    instr_prefetch_queue #(.BUS_W(8), .RESET_PTR(RST_PTR)) u_instr_prefetch_queue_n8 (
        .clk(clk), .rst_n(rst_n), .pop_req(n_pop_req), .pop_valid(n_pop_valid), .pop_data(n_pop_data),
        .flush(1'b0), .flush_addr(20'h0), .data_req(1'b0), .data_addr(20'h0),
        .data_we(1'b0), .data_wdata(8'h00), .data_rdata(n_data_rdata), .data_done(n_data_done),
        .mem_req(n_mem_req), .mem_addr(n_mem_addr), .mem_we(n_mem_we), .mem_wdata(n_mem_wdata),
        .mem_rdata(n_mem_rdata), .mem_ack(n_mem_req)
    );

    // bus monitors
    int w_rises = 0, w_len = 0, n_rises = 0;
    bit w_prev = 0, n_prev = 0;
    logic [19:0] w_first = '0, w_last = '0, n_first = '0, wr_addr = '0;
    logic [15:0] wr_data = '0;

    always @(posedge clk) begin
        if (rst_n) begin
            if (mem_req && !w_prev) begin
                w_rises++; w_last = mem_addr; w_len = 1;
                if (w_rises == 1) w_first = mem_addr;
            end else if (mem_req) w_len++;
            else if (w_prev) chk(w_len == 4, "R2 bus cycle length", w_len, 4);
            if (n_mem_req && !n_prev) begin
                n_rises++;
                if (n_rises == 1) n_first = n_mem_addr;
            end
            if (mem_req && mem_we && mem_ack) begin wr_addr = mem_addr; wr_data = mem_wdata; end
        end
        w_prev = rst_n && mem_req;
        n_prev = rst_n && n_mem_req;
    end

    task automatic pop_n(input int n, input logic [19:0] a, input string req);
        int got = 0, idle = 0, overlap = 0;
        while (got < n && idle < 200) begin
            @(negedge clk);
            if (pop_valid) begin
                chk(pop_data == mb(20'(a + got)), req, pop_data, mb(20'(a + got)));
                if (mem_req && !mem_we) overlap++;
                pop_req = 1'b1; got++;
            end else begin
                pop_req = 1'b0; idle++;
            end
        end
        @(negedge clk); pop_req = 1'b0;
        chk(got == n, {req, " byte count"}, got, n);
        if (n >= 12) chk(overlap > 0, "R4 pop during fetch", overlap, 1);
    endtask

    task automatic do_flush(input logic [19:0] t);
        @(negedge clk); flush = 1'b1; flush_addr = t;
        @(negedge clk); flush = 1'b0; #1;
        chk(pop_valid == 1'b0, "R6 empty after flush", pop_valid, 0);
    endtask

    task automatic data_op(input logic [19:0] a, input bit we, input logic [15:0] wd,
                           output logic [15:0] rd, output int cycles);
        @(negedge clk); data_req = 1'b1; data_addr = a; data_we = we; data_wdata = wd;
        cycles = 0; rd = '0;
        while (cycles < 30) begin
            @(negedge clk); cycles++;
            if (data_done) begin rd = data_rdata; data_req = 1'b0; break; end
        end
        data_req = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] rd;
        int cyc, base, seen;
        repeat (4) @(negedge clk);
        chk(pop_valid == 0 && mem_req == 0, "R1 wide idle in reset", {pop_valid, mem_req}, 0);
        chk(n_pop_valid == 0 && n_mem_req == 0, "R1 narrow idle in reset", {n_pop_valid, n_mem_req}, 0);
        rst_n = 1'b1;
        repeat (60) @(negedge clk);
        chk(w_first == RST_PTR, "R1 first fetch address", w_first, RST_PTR);
        chk(n_first == RST_PTR, "R1 narrow first fetch address", n_first, RST_PTR);
        chk(w_rises == 3, "R10 wide fills in 3 fetches", w_rises, 3);
        chk(n_rises == 4, "R10 narrow fills in 4 fetches", n_rises, 4);
        chk(mem_req == 0 && n_mem_req == 0, "R8 full queue pauses fetch", {mem_req, n_mem_req}, 0);

        pop_n(20, RST_PTR, "R3 wide byte order");

        // narrow drain
        begin
            int got = 0;
            while (got < 10) begin
                @(negedge clk);
                if (n_pop_valid) begin
                    chk(n_pop_data == mb(20'(RST_PTR + got)), "R3 narrow byte order", n_pop_data, mb(20'(RST_PTR + got)));
                    n_pop_req = 1'b1; got++;
                end else n_pop_req = 1'b0;
            end
            @(negedge clk); n_pop_req = 1'b0;
        end

        // odd target: threshold and single-byte first fetch
        repeat (20) @(negedge clk);
        base = w_rises;
        do_flush(20'h00201);
        repeat (40) @(negedge clk);
        chk(w_rises - base == 3, "R9 odd target fetch count", w_rises - base, 3);
        chk(mem_req == 0, "R8 one free byte does not refetch", mem_req, 0);
        pop_n(1, 20'h00201, "R9 odd target first byte");
        seen = 0;
        repeat (3) begin @(negedge clk); if (mem_req) seen = 1; end
        chk(seen == 1, "R8 two free bytes refetch", seen, 1);
        pop_n(19, 20'h00202, "R9 aligned after odd");

        // flush with a fetch in flight
        do_flush(20'h00600);
        while (!mem_req) @(negedge clk);
        flush = 1'b1; flush_addr = 20'h00733;
        @(negedge clk); flush = 1'b0;
        chk(mem_req == 1, "R7 in-flight fetch continues", mem_req, 1);
        pop_n(14, 20'h00733, "R7 dropped data never popped");

        // data read and write on an idle port
        repeat (40) @(negedge clk);
        data_op(20'h00345, 1'b0, 16'h0, rd, cyc);
        chk(rd == {mb(20'h00345), mb(20'h00344)}, "R5 read data", rd, {mb(20'h00345), mb(20'h00344)});
        chk(cyc == 4, "R5 idle data latency", cyc, 4);
        data_op(20'h003A0, 1'b1, 16'hBEEF, rd, cyc);
        @(negedge clk);
        chk(wr_addr == 20'h003A0 && wr_data == 16'hBEEF, "R5 write address and data", {wr_addr[11:0], wr_data}, {12'h3A0, 16'hBEEF});

        // data request during a fetch wins the next bus cycle
        do_flush(20'h00400);
        while (!mem_req) @(negedge clk);
        @(negedge clk);
        base = w_rises;
        data_op(20'h00456, 1'b0, 16'h0, rd, cyc);
        chk(w_rises - base == 1, "R5 data before next fetch", w_rises - base, 1);
        chk(w_last == 20'h00456, "R5 data address on bus", w_last, 20'h00456);
        chk(cyc <= 9, "R5 waits one bus cycle only", cyc, 9);
        pop_n(12, 20'h00400, "R6 flush target order");

        // sweep of target alignments
        for (int t = 0; t < 16; t++) begin
            do_flush(20'(32'h00800 + t * 7));
            pop_n(14, 20'(32'h00800 + t * 7), "R6 target sweep");
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule